// File: doc/BRIEF.md
# Receive Buffer with Character Timeout

This block is the receive side buffering of a classic byte-oriented serial port. A deserializer hands it complete bytes and break events; the block keeps them either in a 16-entry first-in first-out store or, with the buffer mode switched off, in a single holding register. It tracks the data-ready, overrun and break status bits. It compares the fill level against a software-chosen trigger level and raises a character-timeout flag when stored bytes have sat unread for too long.

Software reaches the block through three register paths: a read strobe on the receive buffer register, a write port for the buffer control register, and a status read strobe that clears the sticky error bits. The frame-format bits of the line control register set the character length, and a bit-time tick from the baud generator paces the timeout counter. The length of one character sets the timeout window, so the window tracks the programmed frame format.

Top module: `rx_fifo_timeout`

## Requirements
- R1: Control bits 7:6 select the trigger level (00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes). With buffer mode on, `triggerHit` is high exactly when the fill count is at or above that level. With buffer mode off, it follows data-ready.
- R2: In buffer mode, a byte that arrives while all 16 entries are full is dropped and sets overrun. The stored bytes, their order and the count of 16 are kept.
- R3: With buffer mode off (control bit 0 clear), a byte that arrives while data-ready is set replaces the holding register and sets overrun.
- R4: In buffer mode, every accepted byte restarts a timeout of four character times, counted in `bitTick` pulses. When the timeout expires with a non-empty buffer, `timeoutPending` rises. The counter stays at zero while the buffer is empty, so no timeout arises then.
- R5: A buffer read clears `timeoutPending`. If bytes remain after the read, the four-character timeout starts again from zero.
- R6: `rdData` shows the byte the next read returns: the oldest entry, 0 when the buffer is empty, or the holding register with buffer mode off. The read that empties the buffer clears data-ready and break, and a read of an empty buffer returns 0.
- R7: One character time in bits is 1 + (5 + lcrBits[1:0]) + lcrBits[3] + (lcrBits[2] ? 2 : 1).
- R8: A control write with bit 1 set, or one that changes bit 0, empties the buffer and clears data-ready, break and the timeout.
- R9: A control write retains only bits 7, 6, 3 and 0. `fcrValue` reads back the written value masked with 0xC9.
- R10: A break event stores a zero byte, as if it had been received, and sets both break and data-ready.
- R11: A status read clears overrun and break.
- R12: Bytes leave in arrival order, and `fifoCount` reports 0 to 16 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | One-cycle pulse: a received byte is present on rxData |
| rxData | input | 8 | Received byte |
| rxBreak | input | 1 | One-cycle pulse: a break condition was received |
| bitTick | input | 1 | One pulse per serial bit time |
| lcrBits | input | 4 | Frame format: [1:0] data length code, [2] two stop bits, [3] parity present |
| rdBuf | input | 1 | Read strobe for the receive buffer register |
| statusRead | input | 1 | Read strobe for the line status register |
| fcrWrite | input | 1 | Write strobe for the buffer control register |
| fcrData | input | 8 | Buffer control write data |
| rdData | output | 8 | Value that a buffer read returns this cycle |
| fcrValue | output | 8 | Retained buffer control bits |
| fifoCount | output | 5 | Number of stored entries |
| dataReady | output | 1 | Data-ready status |
| overrun | output | 1 | Overrun status |
| breakSeen | output | 1 | Break status |
| timeoutPending | output | 1 | Character timeout indication |
| triggerHit | output | 1 | Fill level reached the trigger level |

## Verification
A wrong read or write pointer shows at `rdData` on the very next read, so every scenario drains the buffer and compares each byte with the order in which it was written. A count that drifts shows at once on `fifoCount` and `triggerHit`, and a full buffer that accepts a 17th byte shows the wrong oldest byte on the first read after the overrun. A timeout counter that is off by a tick, or that uses the wrong frame length, moves the rise of `timeoutPending` by one pulse. The bench therefore checks the flag one tick before the expected expiry and again at it, for two frame formats.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FCR_KEEP_MASK = 8'hC9;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              push;
    logic              pop;
    logic              flush;
    logic              holdLoad;
    logic [BYTE_W-1:0] byteIn;
  } dpCmd_t;
endpackage

// File: rtl/rx_fifo_dp.sv
module rx_fifo_dp
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  dpCmd_t                       cmd,
  input  logic                         fifoMode,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [BYTE_W-1:0]            rdData
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [BYTE_W-1:0] entry [DEPTH];
  logic [BYTE_W-1:0] holdByte;
  logic [BYTE_W-1:0] headByte;

  // Storage: one register per entry.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry[i] <= '0;
      end else if (cmd.push && wrPtr == PTR_W'(i)) begin
        entry[i] <= cmd.byteIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (cmd.pop) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdByte <= '0;
    end else if (cmd.holdLoad) begin
      holdByte <= cmd.byteIn;
    end
  end

  assign headByte = entry[rdPtr];

  always_comb begin
    if (!fifoMode) begin
      rdData = holdByte;
    end else if (count == CNT_W'(0)) begin
      rdData = '0;
    end else begin
      rdData = headByte;
    end
  end
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter int MAX_CHAR_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxValid,
  input  logic [BYTE_W-1:0]          rxData,
  input  logic                       rxBreak,
  input  logic                       bitTick,
  input  logic [3:0]                 lcrBits,
  input  logic                       rdBuf,
  input  logic                       statusRead,
  input  logic                       fcrWrite,
  input  logic [BYTE_W-1:0]          fcrData,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output dpCmd_t                     cmd,
  output logic                       fifoMode,
  output logic [BYTE_W-1:0]          fcrValue,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       breakSeen,
  output logic                       timeoutPending,
  output logic                       triggerHit
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CHARS * MAX_CHAR_BITS + 1);

  logic [BYTE_W-1:0] fcrReg;
  logic              full, empty, rxEvent, flushRx, lastRead, ovfSet;
  logic [3:0]        charBits;
  logic [TO_W-1:0]   toLimit, toCnt;
  logic [CNT_W-1:0]  trigLevel;

  assign fifoMode = fcrReg[0];
  assign fcrValue = fcrReg;
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == CNT_W'(0));
  assign rxEvent  = rxValid | rxBreak;

  // Frame length: start + data + optional parity + stop bits.
  always_comb begin
    charBits = 4'd6 + {2'b00, lcrBits[1:0]} + {3'b000, lcrBits[3]}
             + (lcrBits[2] ? 4'd2 : 4'd1);
    toLimit  = TO_W'(TIMEOUT_CHARS) * TO_W'(charBits);
  end

  always_comb begin
    case (fcrReg[7:6])
      2'b00:   trigLevel = CNT_W'(1);
      2'b01:   trigLevel = CNT_W'(4);
      2'b10:   trigLevel = CNT_W'(8);
      default: trigLevel = CNT_W'(14);
    endcase
  end

  // Strobe generation.
  always_comb begin
    flushRx      = fcrWrite & (fcrData[1] | (fcrData[0] ^ fcrReg[0]));
    cmd.flush    = flushRx;
    cmd.pop      = fifoMode & rdBuf & ~empty & ~flushRx;
    cmd.push     = fifoMode & rxEvent & (~full | cmd.pop) & ~flushRx;
    cmd.holdLoad = ~fifoMode & rxEvent;
    cmd.byteIn   = rxBreak ? '0 : rxData;
    lastRead     = rdBuf & (fifoMode ? (count <= CNT_W'(1)) : 1'b1);
    ovfSet       = rxEvent & ~flushRx &
                   (fifoMode ? (full & ~cmd.pop) : (dataReady & ~rdBuf));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcrReg <= '0;
    end else if (fcrWrite) begin
      fcrReg <= fcrData & FCR_KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReady <= 1'b0;
      breakSeen <= 1'b0;
    end else if (flushRx) begin
      dataReady <= 1'b0;
      breakSeen <= 1'b0;
    end else begin
      if (rxEvent) begin
        dataReady <= 1'b1;
      end else if (lastRead) begin
        dataReady <= 1'b0;
      end
      if (rxBreak) begin
        breakSeen <= 1'b1;
      end else if (lastRead || statusRead) begin
        breakSeen <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (ovfSet) begin
      overrun <= 1'b1;
    end else if (statusRead) begin
      overrun <= 1'b0;
    end
  end

  // Character timeout counter in bit times.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toCnt <= '0;
    end else if (!fifoMode || flushRx || cmd.push || cmd.pop || empty) begin
      toCnt <= '0;
    end else if (bitTick && !timeoutPending) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeoutPending <= 1'b0;
    end else if (!fifoMode || flushRx || rdBuf) begin
      timeoutPending <= 1'b0;
    end else if (bitTick && !empty && !cmd.push && toCnt == toLimit - 1'b1) begin
      timeoutPending <= 1'b1;
    end
  end

  assign triggerHit = fifoMode ? (count >= trigLevel) : dataReady;
endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter int MAX_CHAR_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxValid,
  input  logic [7:0]                 rxData,
  input  logic                       rxBreak,
  input  logic                       bitTick,
  input  logic [3:0]                 lcrBits,
  input  logic                       rdBuf,
  input  logic                       statusRead,
  input  logic                       fcrWrite,
  input  logic [7:0]                 fcrData,
  output logic [7:0]                 rdData,
  output logic [7:0]                 fcrValue,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       breakSeen,
  output logic                       timeoutPending,
  output logic                       triggerHit
);
  dpCmd_t cmd;
  logic   fifoMode;

  rx_fifo_ctrl #(
    .DEPTH(DEPTH), .TIMEOUT_CHARS(TIMEOUT_CHARS), .MAX_CHAR_BITS(MAX_CHAR_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxData(rxData),
    .rxBreak(rxBreak), .bitTick(bitTick), .lcrBits(lcrBits), .rdBuf(rdBuf),
    .statusRead(statusRead), .fcrWrite(fcrWrite), .fcrData(fcrData),
    .count(fifoCount), .cmd(cmd), .fifoMode(fifoMode), .fcrValue(fcrValue),
    .dataReady(dataReady), .overrun(overrun), .breakSeen(breakSeen),
    .timeoutPending(timeoutPending), .triggerHit(triggerHit)
  );

  rx_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .fifoMode(fifoMode),
    .count(fifoCount), .rdData(rdData)
  );
endmodule

// File: rtl/rx_fifo_chk.sv
module rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rxValid,
  input logic                       rxBreak,
  input logic                       rdBuf,
  input logic                       fcrWrite,
  input logic [7:0]                 fcrData,
  input logic [7:0]                 fcrValue,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic [7:0]                 rdData,
  input logic                       dataReady,
  input logic                       overrun,
  input logic                       timeoutPending
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= CNT_W'(DEPTH));

  // R2
  fifo_overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcrValue[0] && fifoCount == CNT_W'(DEPTH) && rxValid && !rdBuf && !fcrWrite
    |=> overrun && fifoCount == CNT_W'(DEPTH));

  // R4
  pending_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutPending |-> fifoCount != CNT_W'(0));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcrWrite && fcrData[1] |=> fifoCount == CNT_W'(0) && !timeoutPending && !dataReady);

  // R6
  stored_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount != CNT_W'(0) |-> dataReady);

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcrValue[0] && fifoCount == CNT_W'(0) |-> rdData == 8'h00);

  // R10
  break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxBreak && fcrValue[0] && fifoCount == CNT_W'(0) && !fcrWrite && !rdBuf
    |=> rdData == 8'h00 && dataReady && fifoCount == CNT_W'(1));
endmodule

bind rx_fifo_timeout rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxBreak(rxBreak),
  .rdBuf(rdBuf), .fcrWrite(fcrWrite), .fcrData(fcrData), .fcrValue(fcrValue),
  .fifoCount(fifoCount), .rdData(rdData), .dataReady(dataReady),
  .overrun(overrun), .timeoutPending(timeoutPending)
);

// File: tb/rx_fifo_timeout_tb.sv
module rx_fifo_timeout_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       rxBreak = 1'b0;
  logic       bitTick = 1'b0;
  logic [3:0] lcrBits = 4'b0011;
  logic       rdBuf = 1'b0;
  logic       statusRead = 1'b0;
  logic       fcrWrite = 1'b0;
  logic [7:0] fcrData = 8'h00;
  logic [7:0] rdData, fcrValue;
  logic [4:0] fifoCount;
  logic       dataReady, overrun, breakSeen, timeoutPending, triggerHit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rx_fifo_timeout u_dut (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxData(rxData),
    .rxBreak(rxBreak), .bitTick(bitTick), .lcrBits(lcrBits), .rdBuf(rdBuf),
    .statusRead(statusRead), .fcrWrite(fcrWrite), .fcrData(fcrData),
    .rdData(rdData), .fcrValue(fcrValue), .fifoCount(fifoCount),
    .dataReady(dataReady), .overrun(overrun), .breakSeen(breakSeen),
    .timeoutPending(timeoutPending), .triggerHit(triggerHit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rxByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxData = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic rxBrk();
    @(negedge clk); rxBreak = 1'b1;
    @(negedge clk); rxBreak = 1'b0;
  endtask

  task automatic readBuf(output logic [7:0] v);
    @(negedge clk); rdBuf = 1'b1; v = rdData;
    @(negedge clk); rdBuf = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic writeFcr(input logic [7:0] v);
    @(negedge clk); fcrWrite = 1'b1; fcrData = v;
    @(negedge clk); fcrWrite = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bitTick = 1'b1;
      @(negedge clk); bitTick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R12 reset count", 32'(fifoCount), 0);
    chk("R6 reset dataReady", 32'(dataReady), 0);
    chk("R9 reset fcrValue", 32'(fcrValue), 0);
    chk("R4 reset timeoutPending", 32'(timeoutPending), 0);
    chk("R11 reset overrun", 32'(overrun), 0);
  endtask

  task automatic t_holding();
    logic [7:0] v;
    rxByte(8'h41);
    chk("R3 first byte ready", 32'(dataReady), 1);
    chk("R1 trigger follows ready", 32'(triggerHit), 1);
    rxByte(8'h42);
    chk("R3 overrun set", 32'(overrun), 1);
    chk("R3 holding replaced", 32'(rdData), 32'h42);
    readStatus();
    chk("R11 overrun cleared", 32'(overrun), 0);
    readBuf(v);
    chk("R3 read value", 32'(v), 32'h42);
    chk("R6 ready cleared", 32'(dataReady), 0);
  endtask

  task automatic t_mask_trig14();
    writeFcr(8'hFF);
    chk("R9 retained bits", 32'(fcrValue), 32'hC9);
    chk("R8 enable flush", 32'(fifoCount), 0);
    for (int i = 0; i < 13; i++) rxByte(8'(i));
    chk("R1 below 14", 32'(triggerHit), 0);
    rxByte(8'h0D);
    chk("R1 at 14", 32'(triggerHit), 1);
    chk("R12 count 14", 32'(fifoCount), 14);
    writeFcr(8'h43);
    chk("R8 flush count", 32'(fifoCount), 0);
    chk("R8 flush ready", 32'(dataReady), 0);
    chk("R9 retained 0x41", 32'(fcrValue), 32'h41);
  endtask

  task automatic t_order_trig4();
    logic [7:0] v;
    for (int i = 0; i < 3; i++) rxByte(8'hA0 + 8'(i));
    chk("R1 three below 4", 32'(triggerHit), 0);
    rxByte(8'hA3);
    chk("R1 four reaches 4", 32'(triggerHit), 1);
    for (int i = 0; i < 4; i++) begin
      readBuf(v);
      chk("R12 order", 32'(v), 32'hA0 + 32'(i));
    end
    chk("R6 last read clears ready", 32'(dataReady), 0);
    readBuf(v);
    chk("R6 empty read zero", 32'(v), 0);
    writeFcr(8'h81);
    for (int i = 0; i < 7; i++) rxByte(8'h30);
    chk("R1 seven below 8", 32'(triggerHit), 0);
    rxByte(8'h30);
    chk("R1 eight reaches 8", 32'(triggerHit), 1);
    writeFcr(8'h03);
    rxByte(8'h31);
    chk("R1 level 1", 32'(triggerHit), 1);
    writeFcr(8'h43);
  endtask

  task automatic t_overrun_fifo();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) rxByte(8'h10 + 8'(i));
    chk("R12 full count", 32'(fifoCount), 16);
    rxByte(8'hEE);
    chk("R2 overrun set", 32'(overrun), 1);
    chk("R2 count kept", 32'(fifoCount), 16);
    readStatus();
    chk("R11 overrun cleared", 32'(overrun), 0);
    for (int i = 0; i < 16; i++) begin
      readBuf(v);
      chk("R2 contents kept", 32'(v), 32'h10 + 32'(i));
    end
    chk("R6 drained ready", 32'(dataReady), 0);
  endtask

  task automatic t_break();
    logic [7:0] v;
    rxBrk();
    chk("R10 break count", 32'(fifoCount), 1);
    chk("R10 break byte zero", 32'(rdData), 0);
    chk("R10 break bit", 32'(breakSeen), 1);
    chk("R10 ready bit", 32'(dataReady), 1);
    rxByte(8'h55);
    readBuf(v);
    chk("R6 break kept while bytes remain", 32'(breakSeen), 1);
    readBuf(v);
    chk("R6 last read value", 32'(v), 32'h55);
    chk("R6 last read clears break", 32'(breakSeen), 0);
    chk("R6 last read clears ready", 32'(dataReady), 0);
    rxBrk();
    readStatus();
    chk("R11 status read clears break", 32'(breakSeen), 0);
    readBuf(v);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    lcrBits = 4'b0011;
    rxByte(8'hB1);
    rxByte(8'hB2);
    ticks(39);
    chk("R4 no timeout at 39", 32'(timeoutPending), 0);
    ticks(1);
    chk("R4 timeout at 40", 32'(timeoutPending), 1);
    readBuf(v);
    chk("R5 read clears pending", 32'(timeoutPending), 0);
    ticks(39);
    chk("R5 restarted, none at 39", 32'(timeoutPending), 0);
    ticks(1);
    chk("R5 restarted, set at 40", 32'(timeoutPending), 1);
    readBuf(v);
    ticks(60);
    chk("R4 empty holds off timeout", 32'(timeoutPending), 0);
  endtask

  task automatic t_frame_len();
    logic [7:0] v;
    lcrBits = 4'b1100;
    rxByte(8'hC1);
    ticks(35);
    chk("R7 nine-bit frame, none at 35", 32'(timeoutPending), 0);
    ticks(1);
    chk("R7 nine-bit frame, set at 36", 32'(timeoutPending), 1);
    readBuf(v);
    lcrBits = 4'b0011;
  endtask

  task automatic t_disable();
    rxByte(8'hD1);
    writeFcr(8'h00);
    chk("R8 mode change flush", 32'(fifoCount), 0);
    chk("R8 mode change ready", 32'(dataReady), 0);
    rxByte(8'h77);
    chk("R3 holding mode value", 32'(rdData), 32'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_holding();
    t_mask_trig14();
    t_order_trig4();
    t_overrun_fifo();
    t_break();
    t_timeout();
    t_frame_len();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule